// File: doc/BRIEF.md
# Palette Entry Format Converter

This block turns a raw colour-lookup buffer into a normalized palette. When it is triggered, it reads the entries one after another through a byte-addressed source port. Each entry is decoded according to one of four packing formats, and every colour component is widened to 8 bits, left-justified. The result is written, together with a transparency flag, into a palette RAM through a write port. The number of entries comes from the pixel depth code. A grayscale mode copies the low byte of each entry into all three components.

A conversion begins in one of two ways. Software can pulse `start`, or the block starts on its own when the format select on `fmt_sel` no longer matches the format it last converted with. Either way the block has to be idle and the depth code has to be one it supports.

Both data ports use valid/ready handshakes. A source request is held, with a stable address, until `src_req_ready` accepts it. The word comes back on `src_rsp_valid` some later cycle. Only one request is ever outstanding, so the response side has no ready. A palette write is held, with stable index and data, until `pal_wr_ready` accepts it. The next source request follows only after that acceptance, so a stalled RAM stalls the source.

Top module: `palette_conv`

## Requirements
- R1: Depth code 1 converts 4 entries, code 2 converts 16 and code 3 converts 256. Each entry produces exactly one accepted palette write.
- R2: With any other depth code, neither `start` nor a change of `fmt_sel` causes a source request, a palette write or `done`, and neither one changes the recorded last format.
- R3: Format 0 reads entry k at byte address 2k. It uses the low 16 bits of the returned word as red[15:11], green[10:5] and blue[4:0], with transparency 0, and ignores bits 31:16. The written word carries transparency in bit 24, red in 23:16, green in 15:8 and blue in 7:0.
- R4: Formats 1, 2 and 3 read entry k at byte address 4k and take transparency from bit 24 of the returned word.
- R5: Format 1 takes red from bits 23:19, green from 15:10 and blue from 7:3, each left-justified into 8 bits with zero fill.
- R6: Format 2 takes red from bits 23:18, green from 15:10 and blue from 7:2, each left-justified with zero fill.
- R7: Format 3 takes red from bits 23:16, green from 15:8 and blue from 7:0 unchanged.
- R8: With `mono_en` set, all three components equal bits 7:0 of the entry, in every format. Transparency still follows R3 and R4.
- R9: Writes are issued in ascending index order starting at 0, and each entry's source request precedes its write.
- R10: `done` is high for exactly one cycle, in the cycle after the last write is accepted.
- R11: While idle with a supported depth, a `fmt_sel` value that differs from the last converted format starts a conversion without `start`.
- R12: A request or write that is not accepted stays valid, with unchanged address, index and data, in the next cycle.
- R13: Format, grayscale mode and depth are captured when a conversion starts. `start` and input changes during a conversion have no effect on it.
- R14: After reset nothing is requested or written, `done` is low, and the recorded last format is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Palette entry format select (0 to 3) |
| depth_code | input | 4 | Pixel depth code (1, 2, 3 supported) |
| mono_en | input | 1 | Grayscale mode |
| start | input | 1 | Conversion request pulse |
| src_req_valid | output | 1 | Source read request valid |
| src_req_ready | input | 1 | Source read request accepted |
| src_addr | output | ADDR_W (16) | Byte address of the entry |
| src_rsp_valid | input | 1 | Source read data valid |
| src_rsp_data | input | 32 | Little-endian word read at `src_addr` |
| pal_wr_valid | output | 1 | Palette write valid |
| pal_wr_ready | input | 1 | Palette write accepted |
| pal_wr_idx | output | 8 | Palette index |
| pal_wr_data | output | 25 | {transparency, red, green, blue} |
| done | output | 1 | One-cycle completion pulse |

## Verification
A trigger raises `src_req_valid` on the next clock edge. The response is captured on the edge where `src_rsp_valid` is seen, and `pal_wr_valid` rises with the decoded entry right after that edge. `done` follows one edge after the final accepted write. The bench logs every handshake and the `done` pulse at the edge where it completes, each with its cycle stamp. It compares the logged index, address and data with values computed from the requirements, and checks that the `done` stamp is exactly one more than the stamp of the last write. Cases where something must not happen are checked by waiting a fixed number of cycles and confirming that the request, write and `done` counters have not moved.

// File: rtl/palconv_pkg.sv
package palconv_pkg;

  localparam int SRC_W   = 32;
  localparam int COMP_W  = 8;
  localparam int IDX_W   = 8;
  localparam int FMT_W   = 2;
  localparam int DEPTH_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_WRITE,
    ST_DONE
  } palconv_state_e;

  typedef struct packed {
    logic              alpha;
    logic [COMP_W-1:0] red;
    logic [COMP_W-1:0] green;
    logic [COMP_W-1:0] blue;
  } pal_entry_t;

  // depth codes that have a palette at all
  function automatic logic depth_ok(input logic [DEPTH_W-1:0] code);
    case (code)
      4'd1, 4'd2, 4'd3: depth_ok = 1'b1;
      default:          depth_ok = 1'b0;
    endcase
  endfunction

  // index of the final entry for a depth code
  function automatic logic [IDX_W-1:0] depth_last_idx(input logic [DEPTH_W-1:0] code);
    case (code)
      4'd1:    depth_last_idx = IDX_W'(3);
      4'd2:    depth_last_idx = IDX_W'(15);
      4'd3:    depth_last_idx = IDX_W'(255);
      default: depth_last_idx = '0;
    endcase
  endfunction

endpackage

// File: rtl/palconv_trigger.sv
module palconv_trigger
  import palconv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FMT_W-1:0]   fmt_sel,
  input  logic [DEPTH_W-1:0] depth_code,
  input  logic               start,
  input  logic               idle,
  output logic               go,
  output logic [IDX_W-1:0]   go_last_idx
);

  logic [FMT_W-1:0] used_fmt_q;
  logic             fmt_changed;
  logic             supported;

  assign supported   = depth_ok(depth_code);
  assign fmt_changed = (fmt_sel != used_fmt_q);
  assign go          = idle && supported && (start || fmt_changed);
  assign go_last_idx = depth_last_idx(depth_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_fmt_q <= '0;
    end else if (go) begin
      used_fmt_q <= fmt_sel;
    end
  end

endmodule

// File: rtl/palconv_unpack.sv
module palconv_unpack
  import palconv_pkg::*;
(
  input  logic [SRC_W-1:0] raw,
  input  logic [FMT_W-1:0] fmt,
  input  logic             mono,
  output pal_entry_t       entry
);

  logic unused_hi_bits;
  assign unused_hi_bits = ^raw[SRC_W-1:25];

  always_comb begin
    entry = '0;
    case (fmt)
      2'd0: begin
        entry.red   = {raw[15:11], 3'b000};
        entry.green = {raw[10:5],  2'b00};
        entry.blue  = {raw[4:0],   3'b000};
      end
      2'd1: begin
        entry.alpha = raw[24];
        entry.red   = {raw[23:19], 3'b000};
        entry.green = {raw[15:10], 2'b00};
        entry.blue  = {raw[7:3],   3'b000};
      end
      2'd2: begin
        entry.alpha = raw[24];
        entry.red   = {raw[23:18], 2'b00};
        entry.green = {raw[15:10], 2'b00};
        entry.blue  = {raw[7:2],   2'b00};
      end
      default: begin
        entry.alpha = raw[24];
        entry.red   = raw[23:16];
        entry.green = raw[15:8];
        entry.blue  = raw[7:0];
      end
    endcase
    if (mono) begin
      entry.red   = raw[7:0];
      entry.green = raw[7:0];
      entry.blue  = raw[7:0];
    end
  end

endmodule

// File: rtl/palconv_seq.sv
module palconv_seq
  import palconv_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [FMT_W-1:0]  go_fmt,
  input  logic              go_mono,
  input  logic [IDX_W-1:0]  go_last_idx,
  output logic              src_req_valid,
  input  logic              src_req_ready,
  output logic [ADDR_W-1:0] src_addr,
  input  logic              src_rsp_valid,
  input  logic [SRC_W-1:0]  src_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [SRC_W-1:0]  raw_q,
  output logic [FMT_W-1:0]  fmt_q,
  output logic              mono_q,
  output logic              done,
  output logic              idle
);

  localparam int WIDE_SHIFT = 2;
  localparam int NARROW_SHIFT = 1;

  palconv_state_e   state_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_q;
  logic [ADDR_W-1:0] idx_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      fmt_q   <= '0;
      mono_q  <= 1'b0;
      raw_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (go) begin
          state_q <= ST_REQ;
          idx_q   <= '0;
          last_q  <= go_last_idx;
          fmt_q   <= go_fmt;
          mono_q  <= go_mono;
        end
        ST_REQ: if (src_req_ready) begin
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (src_rsp_valid) begin
          raw_q   <= src_rsp_data;
          state_q <= ST_WRITE;
        end
        ST_WRITE: if (wr_ready) begin
          if (idx_q == last_q) begin
            state_q <= ST_DONE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_REQ;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idx_ext       = ADDR_W'(idx_q);
  assign src_addr      = (fmt_q == '0) ? (idx_ext << NARROW_SHIFT) : (idx_ext << WIDE_SHIFT);
  assign src_req_valid = (state_q == ST_REQ);
  assign wr_valid      = (state_q == ST_WRITE);
  assign wr_idx        = idx_q;
  assign done          = (state_q == ST_DONE);
  assign idle          = (state_q == ST_IDLE);

  // R12: an unaccepted request keeps its address
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req_valid && !src_req_ready) |=> (src_req_valid && $stable(src_addr)));

  // R12: an unaccepted write keeps its index
  a_r12_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_idx)));

  // R10: completion is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/palette_conv.sv
module palette_conv
  import palconv_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt_sel,
  input  logic [3:0]        depth_code,
  input  logic              mono_en,
  input  logic              start,
  output logic              src_req_valid,
  input  logic              src_req_ready,
  output logic [ADDR_W-1:0] src_addr,
  input  logic              src_rsp_valid,
  input  logic [31:0]       src_rsp_data,
  output logic              pal_wr_valid,
  input  logic              pal_wr_ready,
  output logic [7:0]        pal_wr_idx,
  output logic [24:0]       pal_wr_data,
  output logic              done
);

  logic             go;
  logic             idle;
  logic [IDX_W-1:0] go_last_idx;
  logic [SRC_W-1:0] raw_q;
  logic [FMT_W-1:0] fmt_q;
  logic             mono_q;
  pal_entry_t       entry;

  palconv_trigger u_trigger (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt_sel    (fmt_sel),
    .depth_code (depth_code),
    .start      (start),
    .idle       (idle),
    .go         (go),
    .go_last_idx(go_last_idx)
  );

  palconv_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (go),
    .go_fmt       (fmt_sel),
    .go_mono      (mono_en),
    .go_last_idx  (go_last_idx),
    .src_req_valid(src_req_valid),
    .src_req_ready(src_req_ready),
    .src_addr     (src_addr),
    .src_rsp_valid(src_rsp_valid),
    .src_rsp_data (src_rsp_data),
    .wr_valid     (pal_wr_valid),
    .wr_ready     (pal_wr_ready),
    .wr_idx       (pal_wr_idx),
    .raw_q        (raw_q),
    .fmt_q        (fmt_q),
    .mono_q       (mono_q),
    .done         (done),
    .idle         (idle)
  );

  palconv_unpack u_unpack (
    .raw  (raw_q),
    .fmt  (fmt_q),
    .mono (mono_q),
    .entry(entry)
  );

  assign pal_wr_data = entry;

  // R12: stalled write data does not move
  a_r12_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_wr_valid && !pal_wr_ready) |=> $stable(pal_wr_data));

  // R10: completion follows an accepted write
  a_r10_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(pal_wr_valid && pal_wr_ready));

  // R3: format 0 never flags transparency
  a_r3_fmt0_opaque: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_wr_valid && (fmt_q == 2'd0)) |-> !pal_wr_data[24]);

  // R9: request, write and completion phases never overlap
  a_r9_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({src_req_valid, pal_wr_valid, done}));

endmodule

// File: tb/test_palette_conv.sv
module test_palette_conv;

  localparam int ADDR_W = 16;
  localparam int NVEC = 11;
  // {fmt[1:0], mono, entry word[31:0], expected[24:0]}
  localparam logic [59:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 32'h0000F81F, 25'h0F800F8},
    {2'd0, 1'b0, 32'h000007E0, 25'h000FC00},
    {2'd0, 1'b1, 32'h0000ABCD, 25'h0CDCDCD},
    {2'd1, 1'b0, 32'h01F8FCF8, 25'h1F8FCF8},
    {2'd1, 1'b0, 32'h00070307, 25'h0000000},
    {2'd2, 1'b0, 32'h0103A5FF, 25'h100A4FC},
    {2'd3, 1'b0, 32'h00123456, 25'h0123456},
    {2'd3, 1'b1, 32'h01123456, 25'h1565656},
    {2'd1, 1'b1, 32'h00ABCDEF, 25'h0EFEFEF},
    {2'd2, 1'b1, 32'h01000080, 25'h1808080},
    {2'd0, 1'b1, 32'h00000111, 25'h0111111}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] fmt_sel = 2'd0;
  logic [3:0] depth_code = 4'd0;
  logic mono_en = 1'b0;
  logic start = 1'b0;
  logic src_req_valid;
  logic src_req_ready = 1'b1;
  logic [ADDR_W-1:0] src_addr;
  logic src_rsp_valid = 1'b0;
  logic [31:0] src_rsp_data = '0;
  logic pal_wr_valid;
  logic pal_wr_ready = 1'b1;
  logic [7:0] pal_wr_idx;
  logic [24:0] pal_wr_data;
  logic done;

  always #10ns clk = ~clk;

  palette_conv #(.ADDR_W(ADDR_W)) i_palette_conv (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .depth_code(depth_code),
    .mono_en(mono_en), .start(start),
    .src_req_valid(src_req_valid), .src_req_ready(src_req_ready), .src_addr(src_addr),
    .src_rsp_valid(src_rsp_valid), .src_rsp_data(src_rsp_data),
    .pal_wr_valid(pal_wr_valid), .pal_wr_ready(pal_wr_ready),
    .pal_wr_idx(pal_wr_idx), .pal_wr_data(pal_wr_data), .done(done)
  );

  logic [7:0] mem [0:1023];
  logic [24:0] exp_data [0:255];
  int cyc = 0;
  bit bp = 1'b0;
  int n_checks = 0;
  int n_fail = 0;
  logic [1:0] exp_fmt = 2'd0;

  int acount = 0, wcount = 0, dcount = 0;
  int last_wr_cyc = 0, done_cyc = 0;
  logic [ADDR_W-1:0] addr_log [0:1023];
  logic [7:0] idx_log [0:1023];
  logic [24:0] data_log [0:1023];

  always @(posedge clk) cyc <= cyc + 1;

  // source memory model, one cycle of read latency
  always @(posedge clk) begin : mem_model
    int a;
    a = int'(src_addr[9:0]);
    if (a > 1020) a = 1020;
    src_rsp_valid <= src_req_valid && src_req_ready;
    src_rsp_data  <= {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  end

  // back-pressure pattern, changed away from the sampling edge
  always @(negedge clk) begin
    pal_wr_ready  <= bp ? ((cyc % 3) != 1) : 1'b1;
    src_req_ready <= bp ? ((cyc % 4) != 0) : 1'b1;
  end

  // handshake monitor
  always @(posedge clk) begin
    if (src_req_valid && src_req_ready) begin
      addr_log[acount % 1024] <= src_addr;
      acount <= acount + 1;
    end
    if (pal_wr_valid && pal_wr_ready) begin
      idx_log[wcount % 1024]  <= pal_wr_idx;
      data_log[wcount % 1024] <= pal_wr_data;
      wcount <= wcount + 1;
      last_wr_cyc <= cyc;
    end
    if (done) begin
      dcount <= dcount + 1;
      done_cyc <= cyc;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
  endtask

  task automatic put_entry(input int k, input logic [1:0] fmt, input logic [31:0] w);
    if (fmt == 2'd0) begin
      mem[2*k]   = w[7:0];
      mem[2*k+1] = w[15:8];
    end else begin
      mem[4*k]   = w[7:0];
      mem[4*k+1] = w[15:8];
      mem[4*k+2] = w[23:16];
      mem[4*k+3] = w[31:24];
    end
  endtask

  // drive a trigger: a format change if one is due, else a start pulse
  task automatic launch(input logic [1:0] fmt, input logic mono, input logic [3:0] depth);
    @(negedge clk);
    mono_en = mono;
    depth_code = depth;
    fmt_sel = fmt;
    if (fmt != exp_fmt) begin
      exp_fmt = fmt;   // R11 path
    end else begin
      start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    int t = 0;
    while (dcount == d0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk("R10 completion seen", 32'(dcount != d0), 32'd1);
  endtask

  // compare a finished conversion against exp_data
  task automatic verify(input string tag, input int w0, input int a0, input int n, input int stride);
    chk("R1 entry count", 32'(wcount - w0), 32'(n));
    chk("R9 request count", 32'(acount - a0), 32'(n));
    chk("R10 done one cycle after last write", 32'(done_cyc), 32'(last_wr_cyc + 1));
    for (int k = 0; k < n; k++) begin
      chk("R9 ascending index", 32'(idx_log[(w0 + k) % 1024]), 32'(k));
      chk(stride == 2 ? "R3 stride" : "R4 stride", 32'(addr_log[(a0 + k) % 1024]), 32'(k * stride));
      chk(tag, 32'(data_log[(w0 + k) % 1024]), 32'(exp_data[k]));
    end
  endtask

  initial begin : watchdog
    #2ms;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    int w0, a0, d0;
    clear_mem();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R14: quiet after reset
    chk("R14 req after reset", 32'(src_req_valid), 32'd0);
    chk("R14 write after reset", 32'(pal_wr_valid), 32'd0);
    chk("R14 done after reset", 32'(done), 32'd0);
    // R14: recorded format is 0, so a supported depth with format 0 does not self-start
    depth_code = 4'd1;
    repeat (12) @(negedge clk);
    chk("R14 no conversion with format 0", 32'(wcount + acount + dcount), 32'd0);

    // table walk: depth code 1, four identical entries
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] f;
      logic m;
      logic [31:0] w;
      string tag;
      f = VEC[v][59:58];
      m = VEC[v][57];
      w = VEC[v][56:25];
      clear_mem();
      for (int k = 0; k < 4; k++) begin
        put_entry(k, f, w);
        exp_data[k] = VEC[v][24:0];
      end
      if (m) tag = "R8 grayscale";
      else if (f == 2'd0) tag = "R3 format0 data";
      else if (f == 2'd1) tag = "R5 format1 data";
      else if (f == 2'd2) tag = "R6 format2 data";
      else tag = "R7 format3 data";
      w0 = wcount; a0 = acount; d0 = dcount;
      launch(f, m, 4'd1);
      wait_done(d0);
      verify(tag, w0, a0, 4, (f == 2'd0) ? 2 : 4);
      chk("R4 transparency bit", 32'(data_log[w0 % 1024][24]), 32'((f != 2'd0) && w[24]));
    end

    // R2: unsupported depth codes ignore start and format change
    w0 = wcount; a0 = acount; d0 = dcount;
    @(negedge clk);
    depth_code = 4'd4;
    fmt_sel = 2'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    depth_code = 4'd0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (25) @(negedge clk);
    chk("R2 no request", 32'(acount - a0), 32'd0);
    chk("R2 no write", 32'(wcount - w0), 32'd0);
    chk("R2 no done", 32'(dcount - d0), 32'd0);

    // R11: format 1 still differs from recorded format 0, so a valid depth starts it
    clear_mem();
    for (int k = 0; k < 4; k++) begin
      put_entry(k, 2'd1, 32'h01F8FCF8);
      exp_data[k] = 25'h1F8FCF8;
    end
    @(negedge clk);
    mono_en = 1'b0;
    depth_code = 4'd1;
    exp_fmt = 2'd1;
    wait_done(d0);
    verify("R11 auto reconversion data", w0, a0, 4, 4);

    // R13 with back-pressure: 16 entries, format 3, start and mono toggled mid-run
    clear_mem();
    for (int k = 0; k < 16; k++) begin
      logic [7:0] kb;
      kb = 8'(k);
      put_entry(k, 2'd3, {7'd0, kb[0], 8'(k * 17), ~kb, kb});
      exp_data[k] = {kb[0], 8'(k * 17), ~kb, kb};
    end
    bp = 1'b1;
    w0 = wcount; a0 = acount; d0 = dcount;
    launch(2'd3, 1'b0, 4'd2);
    repeat (6) @(negedge clk);
    start = 1'b1;
    mono_en = 1'b1;
    depth_code = 4'd3;
    @(negedge clk);
    start = 1'b0;
    mono_en = 1'b0;
    depth_code = 4'd2;
    wait_done(d0);
    repeat (30) @(negedge clk);
    chk("R13 single completion", 32'(dcount - d0), 32'd1);
    verify("R13 settings captured at start", w0, a0, 16, 4);
    bp = 1'b0;
    @(negedge clk);

    // R1: full 256-entry table, format 2
    clear_mem();
    for (int k = 0; k < 256; k++) begin
      logic [7:0] kb;
      kb = 8'(k);
      put_entry(k, 2'd2, {7'd0, kb[0], kb, kb, kb});
      exp_data[k] = {kb[0], kb & 8'hFC, kb & 8'hFC, kb & 8'hFC};
    end
    w0 = wcount; a0 = acount; d0 = dcount;
    launch(2'd2, 1'b0, 4'd3);
    wait_done(d0);
    verify("R6 full table data", w0, a0, 256, 4);
    chk("R1 final index", 32'(idx_log[(w0 + 255) % 1024]), 32'd255);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule